// File: doc/BRIEF.md
# Manchester Subcarrier Keyer

This block turns a serial stream of identifier bits into the on-off keyed subcarrier that switches a tag's load modulator. The carrier-rate divider is outside the block. The block receives the low field of that divider and takes two of its bits directly. The top bit of the field is the bit clock, with one period per data bit. A lower bit is the subcarrier.

Each bit is Manchester coded as the exclusive-or of the held data bit and the bit clock. The coded level then gates the subcarrier: while the level is high the subcarrier passes, and while it is low the output is held at zero. This gives full-depth on-off keying.

A bit boundary is the cycle in which the whole divider field is zero. The serial data input is captured only there, so the upstream serializer may change it at any other time. The coding tap, the subcarrier tap and the held bit are registered together. This keeps them aligned, and the output is registered so that it does not glitch. After reset the output stays low until the first complete bit.

Top module: `subcarrier_keyer`

## Requirements
- R1: The output `loadDrive` is 0 while `rstN` is low. It stays 0 after release until the first clock edge at which `divTaps` is all zero and `rstN` is high has been followed by output of that bit.
- R2: `dataBit` is captured only on a clock edge at which `divTaps` equals zero. Its value at any other edge has no effect on the output.
- R3: While the held bit is 1, the output follows the subcarrier tap `divTaps[SUB_TAP]` when the coding tap `divTaps[CNT_W-1]` is 0 (first half-bit). It is 0 when the coding tap is 1.
- R4: While the held bit is 0, the output is 0 when the coding tap is 0. It follows the subcarrier tap when the coding tap is 1 (second half-bit).
- R5: The output value after clock edge n+1 is computed from the `divTaps` value sampled at edge n. This is a fixed latency of two edges from tap input to output.
- R6: With the defaults (CNT_W=7, SUB_TAP=3), the half-bit that carries the subcarrier holds exactly 4 output pulses of 8 high cycles each over 64 cycles. The other half-bit holds none.
- R7: Runs of identical bits are coded bit by bit. A receiver that counts pulses per half-bit recovers every bit of the input stream in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divTaps | input | CNT_W | Low field of the carrier divider; MSB is the bit clock |
| dataBit | input | 1 | Serial identifier bit, captured at the bit boundary |
| loadDrive | output | 1 | Keyed subcarrier to the load switch |

## Verification
A free-running divider drives the block with a 32-bit stream. The stream mixes long runs of ones and zeros with alternating patterns, so a receiver that only sees level changes cannot hide a missed boundary. Between boundaries the data input carries junk that is the opposite of the next captured value. This separates sampling at the boundary from sampling at any other edge. Reset is released in the middle of a bit, which shows whether the output waits for the first full bit. Each half-bit is decoded by counting pulses, which checks the pulse count and the bit order independently of the cycle-by-cycle compare.

// File: rtl/keyer_pkg.sv
package keyer_pkg;
  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic armed;    // a full bit has begun since reset
    logic heldBit;  // data bit captured at the last boundary
  } keyerStrobesT;
endpackage

// File: rtl/keyer_control.sv
module keyer_control
  import keyer_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] divTaps,
  input  logic             dataBit,
  output keyerStrobesT     strobes
);
  logic atBoundary;
  logic armedQ;
  logic heldQ;

  assign atBoundary = (divTaps == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      heldQ  <= 1'b0;
    end else if (atBoundary) begin
      armedQ <= 1'b1;
      heldQ  <= dataBit;
    end
  end

  assign strobes.armed   = armedQ;
  assign strobes.heldBit = heldQ;

  // R1: arming happens only at a bit boundary
  p_arm_at_boundary_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedQ) |-> $past(divTaps) == '0);

  // R2: the captured bit is untouched between boundaries
  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rstN)
    (divTaps != '0) |=> $stable(heldQ));
endmodule

// File: rtl/keyer_datapath.sv
module keyer_datapath
  import keyer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         codeTap,
  input  logic         subTap,
  input  keyerStrobesT strobes,
  output logic         loadDrive
);
  logic codeQ;
  logic subQ;
  logic driveQ;

  // Align the taps with the bit captured on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= 1'b0;
      subQ  <= 1'b0;
    end else begin
      codeQ <= codeTap;
      subQ  <= subTap;
    end
  end

  // Manchester level gates the subcarrier; registered for a clean edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) driveQ <= 1'b0;
    else       driveQ <= strobes.armed & (strobes.heldBit ^ codeQ) & subQ;
  end

  assign loadDrive = driveQ;

  // R1: no output before the first full bit
  p_mute_unarmed_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.armed |=> !loadDrive);

  // R5: a high output is a subcarrier high seen two edges earlier
  p_sub_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadDrive |-> $past(subTap, 2));

  // R3 and R4: a high output only in the half selected by the held bit
  p_half_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadDrive |-> ($past(codeTap, 2) != $past(strobes.heldBit, 1)));
endmodule

// File: rtl/subcarrier_keyer.sv
module subcarrier_keyer
  import keyer_pkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int SUB_TAP = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] divTaps,
  input  logic             dataBit,
  output logic             loadDrive
);
  localparam int CODE_TAP = CNT_W - 1;

  keyerStrobesT strobes;

  keyer_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .divTaps (divTaps),
    .dataBit (dataBit),
    .strobes (strobes)
  );

  keyer_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .codeTap   (divTaps[CODE_TAP]),
    .subTap    (divTaps[SUB_TAP]),
    .strobes   (strobes),
    .loadDrive (loadDrive)
  );
endmodule

// File: tb/tb_subcarrier_keyer.sv
`timescale 1ns/1ps
module tb_subcarrier_keyer;
  localparam int CNT_W   = 7;
  localparam int SUB_TAP = 3;
  localparam int NBITS   = 32;
  localparam logic [NBITS-1:0] STREAM = 32'hF0CA_5331;
  localparam int RELEASE = 165;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataBit = 1'b0;
  logic [CNT_W-1:0] divTaps = '0;
  logic loadDrive;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  subcarrier_keyer #(.CNT_W(CNT_W), .SUB_TAP(SUB_TAP)) dut (
    .clk(clk), .rstN(rstN), .divTaps(divTaps),
    .dataBit(dataBit), .loadDrive(loadDrive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finishRun();
  end

  initial begin
    int cnt = 0;
    int sendIdx = 0;
    int decIdx = 0;
    bit armedM = 0, heldM = 0, expPend = 0;
    bit lagArmed = 0, lagHeld = 0, inWin = 0, prevOut = 0;
    int lagCnt = 0;
    int firstP = 0, secondP = 0;
    string tag;

    repeat (3) @(negedge clk);
    check(loadDrive == 1'b0, "R1 reset", loadDrive, 0);

    for (int cyc = 0; cyc < 30000 && decIdx < NBITS; cyc++) begin
      @(negedge clk);
      // Per-cycle compare: output now reflects taps sampled one edge earlier.
      if (!lagArmed) tag = "R1";
      else if (lagHeld) tag = "R5 R3";
      else tag = "R5 R4";
      check(loadDrive == expPend, tag, loadDrive, expPend);

      // Pulse-count decoder over half-bits of the lagged count.
      if (lagCnt == 0) begin
        firstP = 0; secondP = 0; inWin = lagArmed;
      end
      if (loadDrive && !prevOut) begin
        if (lagCnt >= 64) secondP++;
        else firstP++;
      end
      prevOut = loadDrive;
      if (lagCnt == 127 && inWin) begin
        bit want;
        want = STREAM[NBITS-1-decIdx];
        check((firstP + secondP == 4) && (firstP == 0 || secondP == 0),
              "R6", firstP * 10 + secondP, want ? 40 : 4);
        check((firstP == 4) == want, "R2 R7", (firstP == 4), want);
        decIdx++;
        inWin = 0;
      end

      // Model update for the edge that sampled the present taps.
      if (!rstN) begin
        armedM = 0; heldM = 0;
      end else if (divTaps == '0) begin
        armedM = 1; heldM = dataBit;
      end
      expPend = armedM & (heldM ^ divTaps[CNT_W-1]) & divTaps[SUB_TAP];
      lagCnt = int'(divTaps);
      lagArmed = armedM;
      lagHeld = heldM;

      // Drive next cycle.
      cnt++;
      divTaps = CNT_W'(cnt);
      if (cyc == RELEASE) rstN = 1'b1;
      if (divTaps == '0 && rstN) begin
        dataBit = (sendIdx < NBITS) ? STREAM[NBITS-1-sendIdx] : 1'b0;
        sendIdx++;
      end else begin
        // Junk between boundaries: opposite of the next captured value.
        dataBit = (sendIdx < NBITS) ? ~STREAM[NBITS-1-sendIdx] : cnt[2];
      end
    end
    check(decIdx == NBITS, "R7 count", decIdx, NBITS);
    finishRun();
  end
endmodule